// File: doc/BRIEF.md
# Single-Wire Autobaud Key-State Responder

This block answers a host that polls the state of ten touch keys over one shared, pulled-up data line. It never speaks first. The host sends a fixed request character at any rate it likes. The block learns that rate from the character itself, with no configured divisor. It then answers on the same line, at the same rate, with two bytes that carry the ten key flags. It drives the line only while that answer is on the wire and leaves it to the pull-up at all other times.

The block also keeps an active-low, open-drain "something changed" flag for the host. The key-detection logic raises the flag whenever any key goes down or up. The flag stays asserted until the host polls, and it is let go before the answer starts. This lets the host skip polling when nothing has moved.

A build parameter selects where the request is received. In the default variant it comes in on the shared line. In the split variant it comes in on a separate receive-only pin, and the shared line carries only the answer.

Top module: `kpr_autobaud_responder`

## Requirements
- R1: After reset the line drive enable `line_oe` is 0 and the change flag is released (`flag_pull` = 0).
- R2: A request is the byte 0x50 sent LSB first, with one low start bit, eight data bits, no parity and one high stop bit. It is accepted at any bit time from MIN_BIT_CLKS to MAX_BIT_CLKS clocks. The bit time is the length of the first low run (start bit plus data bits 0..3, five bit times) divided by five, rounded down.
- R3: The answer uses the measured bit time for every bit. Each of its two bytes is framed as one low start bit, eight data bits LSB first, and one high stop bit. The two bytes go back to back.
- R4: The first answer bit is driven between one and three bit times after the end of the request's stop bit.
- R5: The first answer byte is 0x40 OR keys[5:0]. The second is 0x40 OR keys[9:6] placed in bits 3..0. The keys are sampled in the cycle the request is accepted. For example, keys 0, 2 and 7 give 0x45 then 0x42.
- R6: `line_oe` is 1 only while an answer is being sent. The first driven bit is low. The line is released right after the second stop bit has been driven high for one bit time.
- R7: A well-framed character other than 0x50 (for example 0x51 or 0x70) produces no answer.
- R8: A 0x50 whose stop bit is sampled low (framing error) produces no answer.
- R9: A 0x50 sent with a bit time below MIN_BIT_CLKS or above MAX_BIT_CLKS produces no answer.
- R10: A high `key_change` in a cycle makes `flag_pull` 1 from the next cycle. The flag stays 1 until a request is accepted, which releases it before the answer's first bit.
- R11: If `key_change` is high in the same cycle that a request is accepted, the flag remains pulled.
- R12: With SPLIT_RX = 1 the request is taken from `rx_in`, a request sent on `line_in` is ignored, and the answer still goes out on `line_oe`/`line_out`.
- R13: A request that starts while an answer is pending or being sent is ignored and produces no second answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Sensed level of the shared data line |
| rx_in | input | 1 | Dedicated request input (used only when SPLIT_RX = 1) |
| key_state | input | 10 | Current touch state of keys 9..0, 1 = touched |
| key_change | input | 1 | High in a cycle where any key was pressed or released |
| line_oe | output | 1 | 1 = block drives the shared line with `line_out` |
| line_out | output | 1 | Level driven on the shared line while `line_oe` is 1 |
| flag_pull | output | 1 | 1 = pull the open-drain change flag low |

## Verification
The two functions that can fall in the same cycle are the change-flag set from `key_change` and the flag release caused by accepting a request. The bench provokes the collision by holding `key_change` high across the whole last two bit times of a request, so the acceptance cycle, which happens at mid stop bit, is certainly covered. A reference model is compared on every clock: any cycle after a high `key_change` must show the flag pulled. The model also expects the flag to still be pulled when the answer starts. A follow-up request with `key_change` held low must then release the flag before the answer starts.

// File: rtl/kpr_pkg.sv
package kpr_pkg;

   localparam logic [7:0] REQ_CODE  = 8'h50;
   localparam logic [7:0] MARK_BITS = 8'h40;
   localparam int unsigned N_KEYS   = 10;
   localparam int unsigned RUN_BITS = 5;
   localparam int unsigned TAIL     = 8 - (RUN_BITS - 1);
   localparam int unsigned FRAME_W  = 20;

   typedef enum logic [1:0] {RX_IDLE, RX_LOW, RX_BITS, RX_WAIT_HI} rx_state_e;
   typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_state_e;

   function automatic logic [FRAME_W-1:0] pack_reply(input logic [N_KEYS-1:0] k);
      logic [7:0] lo_b;
      logic [7:0] hi_b;
      lo_b = MARK_BITS | {2'b00, k[5:0]};
      hi_b = MARK_BITS | {4'b0000, k[9:6]};
      return {1'b1, hi_b, 1'b0, 1'b1, lo_b, 1'b0};
   endfunction

endpackage

// File: rtl/kpr_sync2.sv
module kpr_sync2 #(
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= RST_VAL;
         q    <= RST_VAL;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/kpr_autobaud_rx.sv
module kpr_autobaud_rx
   import kpr_pkg::*;
#(
   parameter int unsigned MIN_BIT = 16,
   parameter int unsigned MAX_BIT = 100,
   parameter int unsigned W       = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_s,
   input  logic         hold,
   output logic         accept,
   output logic [W-1:0] bit_t
);
   localparam logic [W-1:0] MIN_V = W'(MIN_BIT);
   localparam logic [W-1:0] MAX_V = W'(MAX_BIT);
   localparam int unsigned  RW    = $clog2(RUN_BITS);
   localparam logic [RW-1:0] R_TOP = RW'(RUN_BITS - 1);
   localparam logic [2:0]   I_TOP = 3'(TAIL);

   rx_state_e      st;
   logic           rx_d;
   logic [W-1:0]   quo;
   logic [RW-1:0]  rem;
   logic [W-1:0]   tmr;
   logic [2:0]     idx;
   logic [TAIL-1:0] got;
   logic           fall;

   assign fall = rx_d & ~rx_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         rx_d   <= 1'b1;
         quo    <= '0;
         rem    <= '0;
         tmr    <= '0;
         idx    <= '0;
         got    <= '0;
         bit_t  <= '0;
         accept <= 1'b0;
      end else begin
         rx_d   <= rx_s;
         accept <= 1'b0;
         if (hold) begin
            st <= RX_IDLE;
         end else begin
            case (st)
               RX_IDLE: begin
                  if (fall) begin
                     st  <= RX_LOW;
                     quo <= '0;
                     rem <= RW'(1);
                  end
               end
               RX_LOW: begin
                  if (rx_s) begin
                     if (quo >= MIN_V && quo <= MAX_V) begin
                        bit_t <= quo;
                        tmr   <= quo >> 1;
                        idx   <= '0;
                        st    <= RX_BITS;
                     end else begin
                        st <= RX_IDLE;
                     end
                  end else if (quo > MAX_V) begin
                     st <= RX_WAIT_HI;
                  end else if (rem == R_TOP) begin
                     rem <= '0;
                     quo <= quo + 1'b1;
                  end else begin
                     rem <= rem + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (tmr == '0) begin
                     tmr <= bit_t - 1'b1;
                     idx <= idx + 1'b1;
                     if (idx == I_TOP) begin
                        st     <= rx_s ? RX_IDLE : RX_WAIT_HI;
                        accept <= rx_s && (got == REQ_CODE[7:RUN_BITS-1]);
                     end else begin
                        got <= {rx_s, got[TAIL-1:1]};
                     end
                  end else begin
                     tmr <= tmr - 1'b1;
                  end
               end
               default: begin
                  if (rx_s) st <= RX_IDLE;
               end
            endcase
         end
      end
   end

   // R2: a learned bit time always lies inside the accepted window
   p_accept_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (bit_t >= MIN_V && bit_t <= MAX_V));

   // R13: nothing is accepted while the transmitter is busy
   p_hold_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !accept);

endmodule

// File: rtl/kpr_reply_tx.sv
module kpr_reply_tx
   import kpr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [W-1:0]      bit_t,
   input  logic [N_KEYS-1:0] keys,
   output logic              busy,
   output logic              oe,
   output logic              dout
);
   localparam logic [4:0] LAST = 5'(FRAME_W - 1);

   tx_state_e          st;
   logic [W:0]         tmr;
   logic [W-1:0]       bt;
   logic [FRAME_W-1:0] sr;
   logic [4:0]         nbit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= TX_IDLE;
         tmr  <= '0;
         bt   <= '0;
         sr   <= '1;
         nbit <= '0;
      end else begin
         case (st)
            TX_IDLE: begin
               if (start) begin
                  bt   <= bit_t;
                  tmr  <= {bit_t, 1'b0} - 1'b1;
                  sr   <= pack_reply(keys);
                  nbit <= '0;
                  st   <= TX_WAIT;
               end
            end
            TX_WAIT: begin
               if (tmr == '0) begin
                  tmr <= {1'b0, bt} - 1'b1;
                  st  <= TX_SEND;
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            default: begin
               if (tmr == '0) begin
                  if (nbit == LAST) begin
                     st <= TX_IDLE;
                  end else begin
                     sr   <= {1'b1, sr[FRAME_W-1:1]};
                     nbit <= nbit + 1'b1;
                     tmr  <= {1'b0, bt} - 1'b1;
                  end
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
         endcase
      end
   end

   assign busy = (st != TX_IDLE);
   assign oe   = (st == TX_SEND);
   assign dout = oe ? sr[0] : 1'b1;

   // R6: every answer opens with a low start bit
   p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> !dout);

   // R6: the line is let go only after a high stop level
   p_release_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe) |-> $past(dout));

   // R3: the bit time stays fixed for the whole answer
   p_rate_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(bt));

endmodule

// File: rtl/kpr_change_flag.sv
module kpr_change_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic change,
   input  logic clear,
   output logic pull
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pull <= 1'b0;
      else if (change) pull <= 1'b1;
      else if (clear)  pull <= 1'b0;
   end

   // R10: a change pulls the flag on the next cycle
   p_set_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
      change |=> pull);

   // R10: a poll with no concurrent change releases the flag
   p_clear_on_poll_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !change) |=> !pull);

   // R11: a change colliding with a poll is not lost
   p_collision_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && change) |=> pull);
endmodule

// File: rtl/kpr_autobaud_responder.sv
module kpr_autobaud_responder
   import kpr_pkg::*;
#(
   parameter int unsigned MIN_BIT_CLKS = 2604,
   parameter int unsigned MAX_BIT_CLKS = 12500,
   parameter bit          SPLIT_RX     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  logic              rx_in,
   input  logic [N_KEYS-1:0] key_state,
   input  logic              key_change,
   output logic              line_oe,
   output logic              line_out,
   output logic              flag_pull
);
   localparam int unsigned W = $clog2(MAX_BIT_CLKS + 2);

   if (MIN_BIT_CLKS < 4) begin : g_bad_min
      $error("MIN_BIT_CLKS must be at least 4");
   end
   if (MAX_BIT_CLKS < MIN_BIT_CLKS) begin : g_bad_max
      $error("MAX_BIT_CLKS must not be below MIN_BIT_CLKS");
   end
   if (REQ_CODE[RUN_BITS-2:0] != '0 || !REQ_CODE[RUN_BITS-1]) begin : g_bad_code
      $error("request code does not open with the expected low run");
   end

   logic         req_pin;
   logic         req_s;
   logic         accept;
   logic         busy;
   logic [W-1:0] bit_t;

   if (SPLIT_RX) begin : g_split_rx
      logic unused_line;
      assign unused_line = line_in;
      assign req_pin     = rx_in;
   end else begin : g_shared_rx
      logic unused_rx;
      assign unused_rx = rx_in;
      assign req_pin   = line_in;
   end

   kpr_sync2 #(.RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_pin),
      .q     (req_s)
   );

   kpr_autobaud_rx #(
      .MIN_BIT (MIN_BIT_CLKS),
      .MAX_BIT (MAX_BIT_CLKS),
      .W       (W)
   ) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_s   (req_s),
      .hold   (busy),
      .accept (accept),
      .bit_t  (bit_t)
   );

   kpr_reply_tx #(.W(W)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .bit_t (bit_t),
      .keys  (key_state),
      .busy  (busy),
      .oe    (line_oe),
      .dout  (line_out)
   );

   kpr_change_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .change (key_change),
      .clear  (accept),
      .pull   (flag_pull)
   );

   // R10: an accepted poll without a new change leaves the flag released at reply start
   p_flag_free_at_reply_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !key_change) |=> !flag_pull);

endmodule

// File: tb/kpr_autobaud_responder_tb_top.sv
module kpr_reply_mon (
   input logic clk,
   input logic oe,
   input logic dout,
   input logic flag,
   input logic kc
);
   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;
   int rises = 0;
   logic [19:0] fq[$];
   int          tq[$];
   int          eq[$];
   logic        flq[$];
   logic        act = 1'b0;
   logic        oe_q = 1'b0;
   logic        kc_q = 1'b0;
   logic        stray = 1'b0;
   logic        ferr = 1'b0;
   logic [19:0] fr = '0;
   logic [19:0] cap = '0;
   int          bt = 1;
   int          pos = 0;

   task automatic expect_frame(input logic [19:0] f, input int t, input logic fl);
      fq.push_back(f);
      tq.push_back(t);
      eq.push_back(cyc);
      flq.push_back(fl);
   endtask

   function automatic int pending();
      return fq.size();
   endfunction

   always @(posedge clk) begin
      #3;
      cyc++;
      if (kc_q) begin
         n_chk++;
         if (flag !== 1'b1) begin
            n_err++;
            $display("FAIL R10/R11 flag after change: got %0b expected 1", flag);
         end
      end
      if (oe && !oe_q) rises++;
      if (!oe) stray = 1'b0;
      if (oe && !act) begin
         if (fq.size() == 0) begin
            if (!stray) begin
               n_chk++; n_err++;
               $display("FAIL R6 unexpected drive: oe=%0b expected 0", oe);
            end
            stray = 1'b1;
         end else begin
            int d;
            logic fl;
            fr = fq.pop_front();
            bt = tq.pop_front();
            d  = cyc - eq.pop_front();
            fl = flq.pop_front();
            act = 1'b1; pos = 0; ferr = 1'b0; cap = '0;
            n_chk++;
            if (d < bt || d > 3 * bt) begin
               n_err++;
               $display("FAIL R4 reply delay: got %0d expected %0d..%0d", d, bt, 3 * bt);
            end
            n_chk++;
            if (flag !== fl) begin
               n_err++;
               $display("FAIL R10/R11 flag at reply start: got %0b expected %0b", flag, fl);
            end
         end
      end
      if (act) begin
         if (!oe || dout !== fr[pos / bt]) ferr = 1'b1;
         if ((pos % bt) == bt / 2) cap[pos / bt] = dout;
         pos++;
         if (pos == 20 * bt) begin
            act = 1'b0;
            n_chk++;
            if (ferr) begin
               n_err++;
               $display("FAIL R3/R5/R6 reply frame: got %h expected %h", cap, fr);
            end
         end
      end
      oe_q = oe;
      kc_q = kc;
   end
endmodule

module kpr_autobaud_responder_tb_top;
   localparam int unsigned MINB = 16;
   localparam int unsigned MAXB = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       h_a = 1'b1, h_b = 1'b1, rx_b = 1'b1;
   logic [9:0] keys_a = '0, keys_b = '0;
   logic       kc_a = 1'b0, kc_b = 1'b0;
   logic       oe_a, out_a, fl_a, oe_b, out_b, fl_b;
   logic       line_a, line_b;

   assign line_a = oe_a ? out_a : h_a;
   assign line_b = oe_b ? out_b : h_b;

   int n_chk = 0;
   int n_err = 0;
   int wd = 0;

   kpr_autobaud_responder #(.MIN_BIT_CLKS(MINB), .MAX_BIT_CLKS(MAXB), .SPLIT_RX(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .line_in(line_a), .rx_in(1'b1),
      .key_state(keys_a), .key_change(kc_a),
      .line_oe(oe_a), .line_out(out_a), .flag_pull(fl_a));

   kpr_autobaud_responder #(.MIN_BIT_CLKS(MINB), .MAX_BIT_CLKS(MAXB), .SPLIT_RX(1'b1)) dut_rx_i (
      .clk(clk), .rst_n(rst_n), .line_in(line_b), .rx_in(rx_b),
      .key_state(keys_b), .key_change(kc_b),
      .line_oe(oe_b), .line_out(out_b), .flag_pull(fl_b));

   kpr_reply_mon mon_a (.clk(clk), .oe(oe_a), .dout(out_a), .flag(fl_a), .kc(kc_a));
   kpr_reply_mon mon_b (.clk(clk), .oe(oe_b), .dout(out_b), .flag(fl_b), .kc(kc_b));

   function automatic logic [19:0] frame_of(input logic [9:0] k);
      logic [7:0] b0, b1;
      b0 = 8'h40 | {2'b00, k[5:0]};
      b1 = 8'h40 | {4'h0, k[9:6]};
      return {1'b1, b1, 1'b0, 1'b1, b0, 1'b0};
   endfunction

   task automatic chk(input logic ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic drive(input int sel, input logic v);
      case (sel)
         0: h_a = v;
         1: rx_b = v;
         default: h_b = v;
      endcase
   endtask

   task automatic send(input int sel, input logic [7:0] c, input int t, input logic stopv);
      logic [9:0] fb;
      fb = {stopv, c, 1'b0};
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         drive(sel, fb[i]);
         repeat (t - 1) @(negedge clk);
      end
      @(negedge clk);
      drive(sel, 1'b1);
   endtask

   task automatic finish_run();
      n_chk += mon_a.n_chk + mon_b.n_chk;
      n_err += mon_a.n_err + mon_b.n_err;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got %0d cycles expected under 150000", wd);
         finish_run();
      end
   end

   initial begin
      int r0;
      repeat (4) @(negedge clk);
      chk(oe_a == 1'b0 && oe_b == 1'b0, "R1 line_oe in reset", int'(oe_a | oe_b), 0);
      chk(fl_a == 1'b0 && fl_b == 1'b0, "R1 flag in reset", int'(fl_a | fl_b), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(oe_a == 1'b0, "R1 line_oe after reset", int'(oe_a), 0);

      // R10: change pulse pulls the flag and it stays pulled
      kc_a = 1'b1; @(negedge clk); kc_a = 1'b0;
      repeat (20) @(negedge clk);
      chk(fl_a == 1'b1, "R10 flag held until poll", int'(fl_a), 1);

      // R2 R3 R4 R5: keys 0,2,7 at bit time 20; keys change after acceptance (snapshot)
      keys_a = 10'b00_1000_0101;
      r0 = mon_a.rises;
      send(0, 8'h50, 20, 1'b1);
      mon_a.expect_frame(frame_of(10'b00_1000_0101), 20, 1'b0);
      chk(frame_of(10'b00_1000_0101) == {1'b1, 8'h42, 1'b0, 1'b1, 8'h45, 1'b0},
          "R5 encoding 0x45/0x42", 0, 0);
      keys_a = 10'h3FF;
      repeat (30 * 20) @(negedge clk);
      chk(mon_a.rises == r0 + 1, "R2 one reply at bit time 20", mon_a.rises - r0, 1);

      // R2 R3: no keys at bit time 57
      keys_a = '0;
      send(0, 8'h50, 57, 1'b1);
      mon_a.expect_frame(frame_of('0), 57, 1'b0);
      repeat (26 * 57) @(negedge clk);

      // R2 boundary: upper limit, all keys
      keys_a = 10'h3FF;
      send(0, 8'h50, MAXB, 1'b1);
      mon_a.expect_frame(frame_of(10'h3FF), MAXB, 1'b0);
      repeat (26 * MAXB) @(negedge clk);

      // R2 boundary: lower limit, key 9 only
      keys_a = 10'h200;
      r0 = mon_a.rises;
      send(0, 8'h50, MINB, 1'b1);
      mon_a.expect_frame(frame_of(10'h200), MINB, 1'b0);
      repeat (26 * MINB) @(negedge clk);
      chk(mon_a.rises == r0 + 1, "R2 reply at minimum bit time", mon_a.rises - r0, 1);

      // R7: other characters
      r0 = mon_a.rises;
      send(0, 8'h51, 20, 1'b1);
      repeat (40 * 20) @(negedge clk);
      send(0, 8'h70, 30, 1'b1);
      repeat (40 * 30) @(negedge clk);
      chk(mon_a.rises == r0, "R7 no reply to 0x51/0x70", mon_a.rises - r0, 0);

      // R8: framing error
      r0 = mon_a.rises;
      send(0, 8'h50, 25, 1'b0);
      repeat (40 * 25) @(negedge clk);
      chk(mon_a.rises == r0, "R8 no reply on framing error", mon_a.rises - r0, 0);

      // R9: out-of-range bit times
      r0 = mon_a.rises;
      send(0, 8'h50, 12, 1'b1);
      repeat (40 * 12) @(negedge clk);
      send(0, 8'h50, 120, 1'b1);
      repeat (30 * 120) @(negedge clk);
      chk(mon_a.rises == r0, "R9 no reply outside rate window", mon_a.rises - r0, 0);

      // R11: change held across the acceptance cycle keeps the flag
      keys_a = 10'h021;
      fork
         send(0, 8'h50, 40, 1'b1);
         begin
            repeat (8 * 40) @(negedge clk);
            kc_a = 1'b1;
            repeat (2 * 40 + 2) @(negedge clk);
            kc_a = 1'b0;
         end
      join
      mon_a.expect_frame(frame_of(10'h021), 40, 1'b1);
      repeat (26 * 40) @(negedge clk);
      chk(fl_a == 1'b1, "R11 flag kept after collision", int'(fl_a), 1);
      send(0, 8'h50, 40, 1'b1);
      mon_a.expect_frame(frame_of(10'h021), 40, 1'b0);
      repeat (26 * 40) @(negedge clk);
      chk(fl_a == 1'b0, "R10 flag released by next poll", int'(fl_a), 0);

      // R12: split receive variant
      keys_b = 10'h201;
      r0 = mon_b.rises;
      send(2, 8'h50, 20, 1'b1);
      repeat (40 * 20) @(negedge clk);
      chk(mon_b.rises == r0, "R12 shared-line request ignored", mon_b.rises - r0, 0);
      send(1, 8'h50, 20, 1'b1);
      mon_b.expect_frame(frame_of(10'h201), 20, 1'b0);
      repeat (26 * 20) @(negedge clk);
      chk(mon_b.rises == r0 + 1, "R12 reply to dedicated-input request", mon_b.rises - r0, 1);

      // R13: second request during a pending reply
      r0 = mon_b.rises;
      send(1, 8'h50, 20, 1'b1);
      mon_b.expect_frame(frame_of(10'h201), 20, 1'b0);
      send(1, 8'h50, 20, 1'b1);
      repeat (40 * 20) @(negedge clk);
      chk(mon_b.rises == r0 + 1, "R13 single reply to overlapped requests", mon_b.rises - r0, 1);

      chk(mon_a.pending() == 0 && mon_b.pending() == 0, "R2 all expected replies seen",
          mon_a.pending() + mon_b.pending(), 0);
      finish_run();
   end
endmodule